// File: doc/BRIEF.md
# Nine-bit three-wire serial display transmitter

This block is a write-only serial link for display controllers that receive the data/command distinction as an extra leading bit in every word, not on a separate pin. The user first stores a data/command flag, opens a transfer, streams bytes through a valid/ready handshake, and closes the transfer. Every byte goes out as a nine-bit word: the stored flag first, then the byte from its most significant bit down.

The serial clock has a selectable sampling level. For every bit the data line is set while the clock sits at the opposite level for a setup interval. The clock then moves to the sampling level for a pulse interval. Chip select is asserted by the open command and released by the close command, each with its own guard interval. All intervals are counted in system clock cycles and set by parameters. The chip select polarity is a parameter, active low by default.

Top module: `spi9_display_tx`

## Requirements
- R1: During and after reset, chip select is at its disabled level, `sck` rests at the sampling level `CLK_PHASE`, `sda` is 0, `byte_ready` is 0, and the stored data/command flag is 0.
- R2: An open command accepted while chip select is disabled drives chip select to its enabled level at the next clock edge. `byte_ready` first rises exactly `POST_EN_CYCLES` cycles after that edge.
- R3: Each accepted byte is sent as a 9-bit word. Word bit 8 is the stored flag and bits 7..0 are the byte. The word leaves most significant bit first, one bit per sampling-level phase of `sck`.
- R4: For each bit, `sck` goes to the non-sampling level (`~CLK_PHASE`) in the same cycle `sda` takes the new bit. It stays there `SETUP_CYCLES` cycles, then stays at the sampling level `PULSE_CYCLES` cycles. `sda` never changes while `sck` is at the sampling level.
- R5: The set-flag command only stores `dc_value`. It changes none of `sck`, `sda` or chip select.
- R6: The flag is taken when a byte is accepted. A set-flag command issued while that byte is shifting applies from the next byte on.
- R7: Between open and close, chip select stays enabled across any number of bytes. `byte_ready` is only high while chip select is enabled.
- R8: A close command accepted while ready keeps chip select enabled for exactly `PRE_DIS_CYCLES` cycles, then disables it. `sck` stays at the sampling level while chip select is disabled.
- R9: `byte_valid` is ignored unless `byte_ready` is high. A byte offered while chip select is disabled produces no clock activity and is never sent.
- R10: A close command while chip select is disabled is ignored. An open command while a transfer is already open is ignored.
- R11: When `byte_valid` and the close command are both high in a ready cycle, the byte is sent and the close command is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_set_dc | input | 1 | Pulse: store `dc_value` as the data/command flag |
| dc_value | input | 1 | Flag value stored by `cmd_set_dc` |
| cmd_open | input | 1 | Pulse: enable chip select and start the post-enable wait |
| cmd_close | input | 1 | Pulse: start the pre-disable wait, then disable chip select |
| byte_valid | input | 1 | A byte is offered on `byte_data` |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Block is ready to take a byte |
| sck | output | 1 | Serial clock |
| sda | output | 1 | Serial data |
| cs | output | 1 | Chip select, enabled level `CS_ACTIVE` |

## Verification
The bench builds the block with a sampling level of 1 and chip select active low. It uses a 2-cycle setup, a 3-cycle pulse, a 4-cycle post-enable wait and a 5-cycle pre-disable wait. These are all different from one another, so an interval that is off by one or swapped shows up as a wrong count. The short bit time makes an exhaustive sweep affordable: all 256 byte values are sent under both flag values. A bench-side receiver captures each word at the sampling edge and times every clock phase. Flag changes in the middle of a byte, commands issued in the wrong state, and a byte arriving together with a close command are also covered.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

  typedef enum logic [2:0] {
    LNK_OFF   = 3'd0,
    LNK_LEAD  = 3'd1,
    LNK_READY = 3'd2,
    LNK_SETUP = 3'd3,
    LNK_HOLD  = 3'd4,
    LNK_TRAIL = 3'd5
  } link_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/spi9_reset_sync.sv
module spi9_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/spi9_delay_timer.sv
module spi9_delay_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi9_word_shifter.sv
module spi9_word_shifter #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  output logic              bit_out,
  output logic              on_last
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  left_q, left_d;

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    if (load) begin
      word_d = load_word;
      left_d = IDX_W'(WORD_W - 1);
    end else if (advance) begin
      word_d = {word_q[WORD_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end

  assign bit_out = word_q[WORD_W-1];
  assign on_last = (left_q == '0);
endmodule

// File: rtl/spi9_link_fsm.sv
module spi9_link_fsm
  import spi9_pkg::*;
#(
  parameter bit CLK_PHASE      = 1'b0,
  parameter int SETUP_CYCLES   = 4,
  parameter int PULSE_CYCLES   = 4,
  parameter int POST_EN_CYCLES = 8,
  parameter int PRE_DIS_CYCLES = 8,
  parameter int CNT_W          = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             byte_valid,
  input  logic             timer_expired,
  input  logic             bit_last,
  output logic             byte_ready,
  output logic             word_load,
  output logic             word_advance,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             sck,
  output logic             cs_enabled
);
  localparam logic [CNT_W-1:0] T_SETUP = CNT_W'(SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] T_PULSE = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] T_POST  = CNT_W'(POST_EN_CYCLES - 1);
  localparam logic [CNT_W-1:0] T_PRE   = CNT_W'(PRE_DIS_CYCLES - 1);

  link_state_t state_q, state_d;
  logic        sck_q, sck_d;
  logic        cs_q, cs_d;

  always_comb begin
    state_d      = state_q;
    sck_d        = sck_q;
    cs_d         = cs_q;
    word_load    = 1'b0;
    word_advance = 1'b0;
    timer_load   = 1'b0;
    timer_val    = '0;
    unique case (state_q)
      LNK_OFF: begin
        if (open_req) begin
          cs_d       = 1'b1;
          state_d    = LNK_LEAD;
          timer_load = 1'b1;
          timer_val  = T_POST;
        end
      end
      LNK_LEAD: begin
        if (timer_expired) state_d = LNK_READY;
      end
      LNK_READY: begin
        if (byte_valid) begin
          word_load  = 1'b1;
          sck_d      = ~CLK_PHASE;
          state_d    = LNK_SETUP;
          timer_load = 1'b1;
          timer_val  = T_SETUP;
        end else if (close_req) begin
          state_d    = LNK_TRAIL;
          timer_load = 1'b1;
          timer_val  = T_PRE;
        end
      end
      LNK_SETUP: begin
        if (timer_expired) begin
          sck_d      = CLK_PHASE;
          state_d    = LNK_HOLD;
          timer_load = 1'b1;
          timer_val  = T_PULSE;
        end
      end
      LNK_HOLD: begin
        if (timer_expired) begin
          if (bit_last) begin
            state_d = LNK_READY;
          end else begin
            word_advance = 1'b1;
            sck_d        = ~CLK_PHASE;
            state_d      = LNK_SETUP;
            timer_load   = 1'b1;
            timer_val    = T_SETUP;
          end
        end
      end
      LNK_TRAIL: begin
        if (timer_expired) begin
          cs_d    = 1'b0;
          state_d = LNK_OFF;
        end
      end
      default: state_d = LNK_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LNK_OFF;
      sck_q   <= CLK_PHASE;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_q    <= cs_d;
    end
  end

  assign byte_ready = (state_q == LNK_READY);
  assign sck        = sck_q;
  assign cs_enabled = cs_q;
endmodule

// File: rtl/spi9_display_tx.sv
module spi9_display_tx
  import spi9_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter bit CLK_PHASE      = 1'b0,
  parameter bit CS_ACTIVE      = 1'b0,
  parameter int SETUP_CYCLES   = 4,
  parameter int PULSE_CYCLES   = 4,
  parameter int POST_EN_CYCLES = 8,
  parameter int PRE_DIS_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set_dc,
  input  logic              dc_value,
  input  logic              cmd_open,
  input  logic              cmd_close,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              sck,
  output logic              sda,
  output logic              cs
);
  localparam int WORD_W  = DATA_W + 1;
  localparam int MAX_CYC = max4(SETUP_CYCLES, PULSE_CYCLES, POST_EN_CYCLES, PRE_DIS_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_sync_n;
  logic             dc_q, dc_d;
  logic             word_load, word_advance, bit_last;
  logic             timer_load, timer_expired;
  logic [CNT_W-1:0] timer_val;
  logic             cs_enabled;

  spi9_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    dc_d = dc_q;
    if (cmd_set_dc) dc_d = dc_value;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dc_q <= 1'b0;
    else             dc_q <= dc_d;
  end

  spi9_link_fsm #(
    .CLK_PHASE      (CLK_PHASE),
    .SETUP_CYCLES   (SETUP_CYCLES),
    .PULSE_CYCLES   (PULSE_CYCLES),
    .POST_EN_CYCLES (POST_EN_CYCLES),
    .PRE_DIS_CYCLES (PRE_DIS_CYCLES),
    .CNT_W          (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .open_req      (cmd_open),
    .close_req     (cmd_close),
    .byte_valid    (byte_valid),
    .timer_expired (timer_expired),
    .bit_last      (bit_last),
    .byte_ready    (byte_ready),
    .word_load     (word_load),
    .word_advance  (word_advance),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .sck           (sck),
    .cs_enabled    (cs_enabled)
  );

  spi9_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  spi9_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (word_load),
    .load_word ({dc_q, byte_data}),
    .advance   (word_advance),
    .bit_out   (sda),
    .on_last   (bit_last)
  );

  assign cs = cs_enabled ? CS_ACTIVE : ~CS_ACTIVE;
endmodule

// File: rtl/spi9_display_tx_checker.sv
module spi9_display_tx_checker #(
  parameter bit CLK_PHASE = 1'b0,
  parameter bit CS_ACTIVE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_set_dc,
  input logic cmd_open,
  input logic byte_valid,
  input logic byte_ready,
  input logic sck,
  input logic sda,
  input logic cs
);
  // R4: data moves only together with a switch to the non-sampling level
  assert_sda_moves_on_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda) |-> (sck == ~CLK_PHASE));

  // R7: ready implies an open transfer
  assert_ready_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (cs == CS_ACTIVE));

  // R8: clock rests at the sampling level while deselected
  assert_sck_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != CS_ACTIVE) |-> (sck == CLK_PHASE));

  // R2: chip select enabling is never accompanied by immediate readiness
  assert_no_early_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs == CS_ACTIVE) && ($past(cs) != CS_ACTIVE)) |-> !byte_ready);

  // R9: an accepted byte leaves the ready state
  assert_accept_leaves_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> (!byte_ready && sck == ~CLK_PHASE));

  // R5: storing the flag while deselected and idle moves no pin
  assert_setdc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set_dc && !cmd_open && (cs != CS_ACTIVE)) |=> ($stable(sck) && $stable(sda) && $stable(cs)));
endmodule

bind spi9_display_tx spi9_display_tx_checker #(
  .CLK_PHASE (CLK_PHASE),
  .CS_ACTIVE (CS_ACTIVE)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_set_dc (cmd_set_dc),
  .cmd_open   (cmd_open),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .sck        (sck),
  .sda        (sda),
  .cs         (cs)
);

// File: tb/spi9_display_tx_test.sv
module spi9_display_tx_test;
  localparam bit PH   = 1'b1;
  localparam bit ACT  = 1'b0;
  localparam int S    = 2;
  localparam int P    = 3;
  localparam int POST = 4;
  localparam int PRE  = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_set_dc, dc_value, cmd_open, cmd_close, byte_valid;
  logic [7:0] byte_data;
  logic       byte_ready, sck, sda, cs;

  int n_checks = 0;
  int n_errors = 0;
  bit dc_model = 1'b0;
  bit expect_on = 1'b0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  spi9_display_tx #(
    .CLK_PHASE(PH), .CS_ACTIVE(ACT), .SETUP_CYCLES(S), .PULSE_CYCLES(P),
    .POST_EN_CYCLES(POST), .PRE_DIS_CYCLES(PRE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_set_dc(cmd_set_dc), .dc_value(dc_value),
    .cmd_open(cmd_open), .cmd_close(cmd_close), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .sck(sck), .sda(sda), .cs(cs)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // receiver: samples at each entry into the sampling level, times both phases
  logic       prev_sck, prev_sda;
  int         lvl_cnt, rx_bits;
  logic [8:0] rx_word;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = PH; prev_sda = 1'b0; lvl_cnt = 0; rx_bits = 0; rx_word = '0;
    end else begin
      if (expect_on && cs != ACT) check(1'b0, "R7 cs dropped in transfer", cs, ACT);
      if (cs == ACT) begin
        if (sck != prev_sck) begin
          if (sck == PH) begin
            check(lvl_cnt == S, "R4 setup length", lvl_cnt, S);
            rx_word = {rx_word[7:0], sda};
            rx_bits++;
            if (rx_bits == 9) begin
              rx_bits = 0;
              if (exp_q.size() == 0) check(1'b0, "R9 spurious word", rx_word, 0);
              else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R3 word", rx_word, e);
              end
            end
          end else if (rx_bits != 0) begin
            check(lvl_cnt == P, "R4 pulse length", lvl_cnt, P);
          end
          lvl_cnt = 1;
        end else begin
          lvl_cnt++;
          if (sck == PH && sda != prev_sda) check(1'b0, "R4 sda moved at sampling level", sda, prev_sda);
        end
      end
      prev_sck = sck;
      prev_sda = sda;
    end
  end

  task automatic set_dc(input bit v);
    @(negedge clk);
    cmd_set_dc = 1'b1; dc_value = v;
    @(negedge clk);
    cmd_set_dc = 1'b0;
    dc_model = v;
  endtask

  task automatic send(input logic [7:0] b);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1; byte_data = b;
    exp_q.push_back({dc_model, b});
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !byte_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int k;
    logic s0, d0, c0;
    rst_n = 1'b0; cmd_set_dc = 0; dc_value = 0; cmd_open = 0; cmd_close = 0;
    byte_valid = 0; byte_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs == ~ACT, "R1 cs in reset", cs, ~ACT);
    check(sck == PH, "R1 sck in reset", sck, PH);
    check(sda == 1'b0, "R1 sda in reset", sda, 0);
    check(byte_ready == 1'b0, "R1 ready in reset", byte_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: close while deselected is ignored
    cmd_close = 1'b1; @(negedge clk); cmd_close = 1'b0;
    repeat (4) @(negedge clk);
    check(cs == ~ACT && !byte_ready, "R10 close while off", {cs, byte_ready}, {~ACT, 1'b0});

    // R9: byte offered while deselected is ignored
    byte_valid = 1'b1; byte_data = 8'hFF;
    repeat (5) @(negedge clk);
    check(sck == PH && sda == 1'b0, "R9 no clocking while off", {sck, sda}, {PH, 1'b0});
    byte_valid = 1'b0;

    // R2: open command and post-enable wait
    cmd_open = 1'b1; @(negedge clk); cmd_open = 1'b0;
    check(cs == ACT, "R2 cs enabled next edge", cs, ACT);
    k = 0;
    while (!byte_ready && k < 50) begin k++; @(negedge clk); end
    check(k == POST, "R2 post-enable wait", k, POST);
    expect_on = 1'b1;

    // R10: open while already open is ignored
    cmd_open = 1'b1; @(negedge clk); cmd_open = 1'b0;
    check(byte_ready && cs == ACT, "R10 open while open", {byte_ready, cs}, {1'b1, ACT});

    // R5: set-flag moves no pin
    s0 = sck; d0 = sda; c0 = cs;
    set_dc(1'b1);
    repeat (2) @(negedge clk);
    check(sck == s0 && sda == d0 && cs == c0 && byte_ready, "R5 set-flag pins unchanged",
          {sck, sda, cs}, {s0, d0, c0});
    set_dc(1'b0);

    // R3 / R7: exhaustive sweep under both flag values
    for (int dc = 0; dc < 2; dc++) begin
      set_dc(dc[0]);
      for (int b = 0; b < 256; b++) send(b[7:0]);
      drain();
    end

    // R6: flag change while a byte shifts applies to the next byte
    send(8'hA5);
    repeat (3) @(negedge clk);
    set_dc(1'b0);
    send(8'h5A);
    drain();
    check(dc_model == 1'b0, "R6 model flag", dc_model, 0);

    // R11: byte and close together, byte wins
    byte_valid = 1'b1; byte_data = 8'h3C; cmd_close = 1'b1;
    exp_q.push_back({dc_model, 8'h3C});
    @(negedge clk);
    byte_valid = 1'b0; cmd_close = 1'b0;
    check(!byte_ready && cs == ACT && sck == ~PH, "R11 byte taken over close",
          {byte_ready, cs, sck}, {1'b0, ACT, ~PH});
    drain();
    repeat (3) @(negedge clk);
    check(byte_ready && cs == ACT, "R11 close dropped", {byte_ready, cs}, {1'b1, ACT});

    // R8: close with pre-disable wait
    expect_on = 1'b0;
    cmd_close = 1'b1; @(negedge clk); cmd_close = 1'b0;
    k = 0;
    while (cs == ACT && k < 50) begin k++; @(negedge clk); end
    check(k == PRE, "R8 pre-disable wait", k, PRE);
    check(sck == PH && !byte_ready, "R8 idle after close", {sck, byte_ready}, {PH, 1'b0});
    repeat (4) @(negedge clk);
    check(cs == ~ACT, "R8 stays deselected", cs, ~ACT);
    check(exp_q.size() == 0, "R3 all words received", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule